// File: doc/BRIEF.md
# Timer and External Interrupt Flag Register

This block is the combined timer-run and interrupt-flag control register of an 8-bit microcontroller. It holds a run bit for each of two timers and an overflow request flag for each of them. It also holds a request flag and a trigger-type bit for each of two external interrupt inputs. The timers read the run bits. The interrupt priority logic reads the four request flags and answers with acknowledge strobes when it vectors to a source.

Each external input passes through a two-flop synchronizer. When its type bit is 1, a high-to-low transition on the synchronized level sets a latched request, and vectoring clears that request. When its type bit is 0, the request is not stored and simply mirrors the inverted synchronized level. Software reads and writes the whole register through a byte-wide port at address 88h. The bit positions are fixed because the firmware decodes them.

Top module: `timer_irq_flags`

## Requirements
- R1: While reset is asserted, and on leaving it, every register bit reads 0 and all run and request outputs are 0.
- R2: A read with address 88h returns {overflow flag 1, run 1, overflow flag 0, run 0, ext request 1, type 1, ext request 0, type 0}, from bit 7 down to bit 0. The ext request bits show the value presented on reqExt.
- R3: An overflow pulse on ovfPulse[n] makes reqTmr[n] 1 from the next clock edge.
- R4: An acknowledge on ackTmr[n] clears reqTmr[n] at the next edge, unless an overflow or a register write sets it in that same cycle.
- R5: A write to address 88h loads the run, type and overflow bits from the written byte. The run and type bits change only through such a write.
- R6: With type bit n at 1, the pin is sampled by two flops. A synchronized level that is high in one cycle and low in the next latches reqExt[n]. A pin that falls before edge k shows the request after edge k+2. The latched request holds while the pin stays low or returns high.
- R7: With type bit n at 1, ackExt[n] clears the latched request at the next edge. A write to address 88h loads the request from bit 3 (input 1) or bit 1 (input 0) of the byte.
- R8: With type bit n at 0, reqExt[n] equals the inverted pin delayed by two edges. Acknowledges and register writes of the request bit have no effect in this mode.
- R9: A hardware set (an overflow pulse, or a detected falling edge in edge mode) takes precedence over a software write of 0 and over an acknowledge in the same cycle.
- R10: A write to any address other than 88h changes no bit. A read from any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 2 | Raw external interrupt pins, idle high |
| ovfPulse | input | 2 | One-cycle overflow pulses from timer 1 and timer 0 |
| ackTmr | input | 2 | Vectoring acknowledge for each timer request |
| ackExt | input | 2 | Vectoring acknowledge for each external request |
| regAddr | input | 8 | Register port address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational, 0 on address miss) |
| runTmr | output | 2 | Run-control bits to the timers |
| reqTmr | output | 2 | Timer overflow requests to the priority logic |
| reqExt | output | 2 | External interrupt requests to the priority logic |

## Verification
The hardest situation to reach is a detected falling edge that arrives in the same cycle as an acknowledge or a software write of 0. The detection sits three edges behind the pin, so the stimulus must schedule the pin drop two cycles ahead of the clearing action. A directed sequence does this for both inputs. Constrained-random traffic then drops pins, pulses overflows, acknowledges and writes the register with independent low probabilities. It also toggles the type bits, so that edges and level windows overlap with clears in many combinations.

// File: rtl/tic_pkg.sv
package tic_pkg;
  localparam int NUM_CH = 2;
  localparam int REG_W  = 8;

  // bit positions are decoded by firmware, so they are fixed
  function automatic int tfPos(int ch);  return ch == 1 ? 7 : 5; endfunction
  function automatic int trPos(int ch);  return ch == 1 ? 6 : 4; endfunction
  function automatic int iePos(int ch);  return ch == 1 ? 3 : 1; endfunction
  function automatic int itPos(int ch);  return ch == 1 ? 2 : 0; endfunction

  typedef struct packed {
    logic [NUM_CH-1:0] tfWr;
    logic [NUM_CH-1:0] trWr;
    logic [NUM_CH-1:0] ieWr;
    logic [NUM_CH-1:0] itWr;
    logic [REG_W-1:0]  data;
  } ticStrobes_t;
endpackage

// File: rtl/tic_ctrl.sv
module tic_ctrl
  import tic_pkg::*;
#(
  parameter logic [7:0] REG_ADDR = 8'h88
) (
  input  logic [7:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic [REG_W-1:0] regImage,
  output ticStrobes_t      strobes,
  output logic [REG_W-1:0] regRdData
);
  logic addrHit;
  logic wrHit;

  assign addrHit = (regAddr == REG_ADDR);
  assign wrHit   = addrHit && regWrEn;

  always_comb begin
    strobes.tfWr = {NUM_CH{wrHit}};
    strobes.trWr = {NUM_CH{wrHit}};
    strobes.ieWr = {NUM_CH{wrHit}};
    strobes.itWr = {NUM_CH{wrHit}};
    strobes.data = regWrData;
  end

  assign regRdData = addrHit ? regImage : '0;
endmodule

// File: rtl/tic_datapath.sv
module tic_datapath
  import tic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] extPin,
  input  logic [NUM_CH-1:0] ovfPulse,
  input  logic [NUM_CH-1:0] ackTmr,
  input  logic [NUM_CH-1:0] ackExt,
  input  ticStrobes_t       strobes,
  output logic [NUM_CH-1:0] runTmr,
  output logic [NUM_CH-1:0] reqTmr,
  output logic [NUM_CH-1:0] reqExt,
  output logic [NUM_CH-1:0] typeBits,
  output logic [REG_W-1:0]  regImage
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_CH-1:0] synced;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SYNC_STAGES-1:0] chain;
    logic prevLvl;
    logic fallSeen;
    logic ieLatch;
    logic tfReg;
    logic trReg;
    logic itReg;

    // pin synchronizer, idle level is high
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain   <= '1;
        prevLvl <= 1'b1;
      end else begin
        chain   <= {chain[SYNC_STAGES-2:0], extPin[c]};
        prevLvl <= chain[LAST];
      end
    end

    assign synced[c] = chain[LAST];
    assign fallSeen  = prevLvl && !chain[LAST];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ieLatch <= 1'b0;
      end else if (!itReg) begin
        ieLatch <= 1'b0;
      end else if (fallSeen) begin
        ieLatch <= 1'b1;
      end else if (strobes.ieWr[c]) begin
        ieLatch <= strobes.data[iePos(c)];
      end else if (ackExt[c]) begin
        ieLatch <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tfReg <= 1'b0;
      end else if (ovfPulse[c]) begin
        tfReg <= 1'b1;
      end else if (strobes.tfWr[c]) begin
        tfReg <= strobes.data[tfPos(c)];
      end else if (ackTmr[c]) begin
        tfReg <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        trReg <= 1'b0;
        itReg <= 1'b0;
      end else begin
        if (strobes.trWr[c]) trReg <= strobes.data[trPos(c)];
        if (strobes.itWr[c]) itReg <= strobes.data[itPos(c)];
      end
    end

    assign reqExt[c]   = itReg ? ieLatch : !synced[c];
    assign reqTmr[c]   = tfReg;
    assign runTmr[c]   = trReg;
    assign typeBits[c] = itReg;

    assign regImage[tfPos(c)] = tfReg;
    assign regImage[trPos(c)] = trReg;
    assign regImage[iePos(c)] = reqExt[c];
    assign regImage[itPos(c)] = itReg;
  end
endmodule

// File: rtl/timer_irq_flags.sv
module timer_irq_flags
  import tic_pkg::*;
#(
  parameter logic [7:0] REG_ADDR    = 8'h88,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] extPin,
  input  logic [1:0] ovfPulse,
  input  logic [1:0] ackTmr,
  input  logic [1:0] ackExt,
  input  logic [7:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic [1:0] runTmr,
  output logic [1:0] reqTmr,
  output logic [1:0] reqExt
);
  ticStrobes_t      strobes;
  logic [REG_W-1:0] regImage;
  logic [1:0]       typeBits;

  tic_ctrl #(.REG_ADDR(REG_ADDR)) u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regImage  (regImage),
    .strobes   (strobes),
    .regRdData (regRdData)
  );

  tic_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .extPin   (extPin),
    .ovfPulse (ovfPulse),
    .ackTmr   (ackTmr),
    .ackExt   (ackExt),
    .strobes  (strobes),
    .runTmr   (runTmr),
    .reqTmr   (reqTmr),
    .reqExt   (reqExt),
    .typeBits (typeBits),
    .regImage (regImage)
  );
endmodule

// File: rtl/timer_irq_flags_chk.sv
module timer_irq_flags_chk #(
  parameter logic [7:0] REG_ADDR = 8'h88
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] ovfPulse,
  input logic [1:0] ackTmr,
  input logic [1:0] ackExt,
  input logic [7:0] regAddr,
  input logic       regWrEn,
  input logic [1:0] runTmr,
  input logic [1:0] reqTmr,
  input logic [1:0] reqExt,
  input logic [1:0] typeBits
);
  logic wrHit;
  logic wrMiss;
  assign wrHit  = regWrEn && (regAddr == REG_ADDR);
  assign wrMiss = regWrEn && (regAddr != REG_ADDR);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (runTmr == 2'b00 && reqTmr == 2'b00 && typeBits == 2'b00)); // R1

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse[0] |=> reqTmr[0]); // R3

  AST_ACK_CLEARS_TF: assert property (@(posedge clk) disable iff (!rstN)
    (ackTmr[1] && !ovfPulse[1] && !wrHit) |=> !reqTmr[1]); // R4

  AST_RUN_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !wrHit |=> $stable(runTmr) && $stable(typeBits)); // R5

  AST_EDGE_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (typeBits[0] && reqExt[0] && !ackExt[0] && !wrHit) |=> reqExt[0]); // R6

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrMiss && !ovfPulse[0] && !ackTmr[0]) |=> $stable(reqTmr[0])); // R10
endmodule

bind timer_irq_flags timer_irq_flags_chk #(.REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/timer_irq_flags_bench.sv
module timer_irq_flags_bench;
  localparam logic [7:0] ADDR = 8'h88;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] extPin = 2'b11;
  logic [1:0] ovfPulse = '0;
  logic [1:0] ackTmr = '0;
  logic [1:0] ackExt = '0;
  logic [7:0] regAddr = ADDR;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] runTmr;
  logic [1:0] reqTmr;
  logic [1:0] reqExt;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  timer_irq_flags u_timer_irq_flags (.*);

  // expected-state model built from the requirements
  logic [1:0] mS1, mS2, mPrev, mIe, mTf, mTr, mIt;

  function automatic logic [1:0] expReqExt();
    logic [1:0] r;
    for (int c = 0; c < 2; c++) r[c] = mIt[c] ? mIe[c] : !mS2[c];
    return r;
  endfunction

  function automatic logic [7:0] expRead();
    logic [1:0] e = expReqExt();
    if (regAddr != ADDR) return 8'h00;
    return {mTf[1], mTr[1], mTf[0], mTr[0], e[1], mIt[1], e[0], mIt[0]};
  endfunction

  task automatic modelReset();
    mS1 = 2'b11; mS2 = 2'b11; mPrev = 2'b11;
    mIe = '0; mTf = '0; mTr = '0; mIt = '0;
  endtask

  task automatic modelClock();
    logic       hit = regWrEn && (regAddr == ADDR);
    logic [1:0] fall = mPrev & ~mS2;
    logic [1:0] nIe, nTf;
    if (!rstN) begin modelReset(); return; end
    for (int c = 0; c < 2; c++) begin
      int tfB = c ? 7 : 5;
      int trB = c ? 6 : 4;
      int ieB = c ? 3 : 1;
      int itB = c ? 2 : 0;
      if (!mIt[c])            nIe[c] = 1'b0;
      else if (fall[c])       nIe[c] = 1'b1;
      else if (hit)           nIe[c] = regWrData[ieB];
      else if (ackExt[c])     nIe[c] = 1'b0;
      else                    nIe[c] = mIe[c];
      if (ovfPulse[c])        nTf[c] = 1'b1;
      else if (hit)           nTf[c] = regWrData[tfB];
      else if (ackTmr[c])     nTf[c] = 1'b0;
      else                    nTf[c] = mTf[c];
      if (hit) begin
        mTr[c] = regWrData[trB];
        mIt[c] = regWrData[itB];
      end
    end
    mIe = nIe; mTf = nTf;
    mPrev = mS2; mS2 = mS1; mS1 = extPin;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: edge, model update, sample on the falling edge
  task automatic step(string tag);
    @(posedge clk);
    modelClock();
    @(negedge clk);
    chk({tag, " R3/R4 reqTmr"}, {6'b0, reqTmr}, {6'b0, mTf});
    chk({tag, " R5 runTmr"},    {6'b0, runTmr}, {6'b0, mTr});
    chk({tag, " R6/R8 reqExt"}, {6'b0, reqExt}, {6'b0, expReqExt()});
    chk({tag, " R2 read"},      regRdData,      expRead());
  endtask

  task automatic idleInputs();
    ovfPulse = '0; ackTmr = '0; ackExt = '0; regWrEn = 1'b0; regAddr = ADDR;
  endtask

  task automatic wrReg(logic [7:0] d, string tag);
    regWrEn = 1'b1; regAddr = ADDR; regWrData = d;
    step(tag);
    regWrEn = 1'b0;
  endtask

  initial begin : watchdog
    #(20 * 60000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: everything zero during reset
    chk("R1 read in reset", regRdData, 8'h00);
    chk("R1 outputs in reset", {2'b0, runTmr, reqTmr, reqExt}, 8'h00);
    rstN = 1'b1;
    step("R1 after release");
    chk("R1 read after release", regRdData, 8'h00);

    // R5/R2: write and read back the layout
    wrReg(8'b1101_0101, "R5 write");
    chk("R2 bit order", regRdData, 8'b1101_0101 & 8'b1111_0101);
    wrReg(8'h00, "R5 clear");

    // R3/R4: overflow then acknowledge
    ovfPulse = 2'b01; step("R3 ovf0");
    chk("R3 tf0 set", {6'b0, reqTmr}, 8'h01);
    ovfPulse = 2'b00; ackTmr = 2'b01; step("R4 ack0");
    chk("R4 tf0 cleared", {6'b0, reqTmr}, 8'h00);
    ackTmr = 2'b00;

    // R9: overflow together with ack and software clear
    ovfPulse = 2'b10; ackTmr = 2'b10; regWrEn = 1'b1; regWrData = 8'h00;
    step("R9 ovf wins");
    chk("R9 tf1 kept", {6'b0, reqTmr}, 8'h02);
    idleInputs();

    // R10: miss address writes and reads
    regAddr = 8'h89; regWrEn = 1'b1; regWrData = 8'hFF;
    step("R10 miss write");
    chk("R10 miss read", regRdData, 8'h00);
    idleInputs(); step("R10 after");
    chk("R10 run unchanged", {6'b0, runTmr}, 8'h00);

    // R6/R7/R9: edge mode on both inputs
    wrReg(8'b0000_0101, "R6 set edge type");
    extPin = 2'b00;               // falls before edge k
    step("R6 k");
    chk("R6 not yet k", {6'b0, reqExt}, 8'h00);
    step("R6 k+1");
    chk("R6 not yet k+1", {6'b0, reqExt}, 8'h00);
    ackExt = 2'b11; regWrEn = 1'b1; regWrData = 8'b0000_0101;
    step("R9 edge beats ack and write");
    chk("R9 edge latched", {6'b0, reqExt}, 8'h03);
    idleInputs(); extPin = 2'b11;
    step("R6 hold");
    chk("R6 latched after pin high", {6'b0, reqExt}, 8'h03);
    ackExt = 2'b01; step("R7 ack0");
    chk("R7 ext0 cleared", {6'b0, reqExt}, 8'h02);
    ackExt = 2'b00;
    wrReg(8'b0000_0101, "R7 write clears ext1");
    chk("R7 ext1 cleared", {6'b0, reqExt}, 8'h00);

    // R8: level mode follows the pin, acks ignored
    wrReg(8'h00, "R8 level type");
    extPin = 2'b10; step("R8 a"); step("R8 b");
    chk("R8 level low", {6'b0, reqExt}, 8'h01);
    ackExt = 2'b01; regWrEn = 1'b1; regWrData = 8'h00;
    step("R8 ack ignored");
    chk("R8 still low", {6'b0, reqExt}, 8'h01);
    idleInputs(); extPin = 2'b11; step("R8 c"); step("R8 d");
    chk("R8 released", {6'b0, reqExt}, 8'h00);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r = $urandom;
      if (r[3:0] == 0) extPin[0] = ~extPin[0];
      if (r[7:4] == 0) extPin[1] = ~extPin[1];
      ovfPulse = {r[10:8] == 0, r[13:11] == 0};
      ackTmr   = {r[16:14] == 0, r[19:17] == 0};
      ackExt   = {r[22:20] == 0, r[25:23] == 0};
      regWrEn  = (r[28:26] == 0);
      regAddr  = r[29] ? 8'h87 : ADDR;
      regWrData = 8'($urandom);
      step("R9 random");
    end
    idleInputs();
    step("R2 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule